// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands commands to a system controller and collects the answers. The host sees a 256-byte window on a plain 32-bit register bus with byte enables. It loads optional payload bytes into a write buffer and sets a source and a destination pointer. It then writes a command word, which interrupts the controller and marks the mailbox busy. The host polls the status word, or waits for a completion interrupt, and then fetches any reply bytes from the read buffer.

The controller side has its own port. It sees the last accepted command word, the two pointers and any word of the write buffer. It fills the read buffer word by word with byte enables. It finishes a command with a single completion pulse that also carries an error flag and an 8-bit error code. Busy is set only by an accepted command write and cleared only by that completion pulse. A command written while busy is still set is thrown away and leaves a sticky overrun mark in the status word.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word (offset 0x04) reads as INIT_ID in bits 15:8 with every other bit zero, and both interrupt outputs are low.
- R2: A host write to offset 0x00 while not busy is accepted. On the next cycle ctrlIrq is high for exactly one cycle, ctrlCmd holds the written word, and status shows busy (bit 0) and the command id taken from command bits 15:12 in status bits 7:4.
- R3: Busy stays set until ctrlDone is pulsed. A ctrlDone pulse while not busy changes nothing.
- R4: A completion loads the error flag (status bit 1) and the error code (status bits 23:16) in the same cycle that busy clears. An accepted command clears both.
- R5: hostIrq pulses for one cycle, in the cycle after completion, only when the accepted command had bit 8 (completion interrupt request) set.
- R6: A command write while busy is dropped: ctrlCmd and the status command id keep their values, no ctrlIrq pulse follows, and status bit 2 (overrun) is set. The overrun bit stays set until the next accepted command clears it.
- R7: Reads of the command word, the pointers, the write buffer and any unmapped offset return zero. Status bits 31:24 and 3 always read zero.
- R8: Word-aligned host writes to offset 0x08 (source) and 0x0C (destination) update only the bytes whose enables are set, and appear on ctrlSrcPtr and ctrlDstPtr.
- R9: A host write at offset 0x80 + 4k (k from 0 to 3) updates the enabled bytes of write-buffer word k, which ctrlWbufData shows when ctrlWbufIdx is k. Byte j of a word lives in bits 8j+7:8j.
- R10: The read buffer changes only through the controller port (word index, byte enables). Host writes to the read buffer or to the status word change nothing.
- R11: A host read at offset 0x90 + n (n from 0 to 15) returns read-buffer bytes n, n+1, n+2, n+3 in bits 7:0, 15:8, 23:16 and 31:24. Bytes past the end of the buffer read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Byte offset within the window |
| hostWdata | input | 32 | Host write data |
| hostBe | input | 4 | Host byte enables for writes |
| hostRdata | output | 32 | Host read data, valid in the cycle of the read |
| hostIrq | output | 1 | One-cycle completion pulse to the host |
| ctrlIrq | output | 1 | One-cycle new-command pulse to the controller |
| ctrlBusy | output | 1 | Mailbox busy flag |
| ctrlCmd | output | 32 | Last accepted command word |
| ctrlSrcPtr | output | 32 | Source pointer |
| ctrlDstPtr | output | 32 | Destination pointer |
| ctrlWbufIdx | input | 2 | Write-buffer word index for the controller |
| ctrlWbufData | output | 32 | Selected write-buffer word |
| ctrlRbufWe | input | 1 | Controller write strobe to the read buffer |
| ctrlRbufIdx | input | 2 | Read-buffer word index for the controller |
| ctrlRbufBe | input | 4 | Byte enables for the read-buffer write |
| ctrlRbufData | input | 32 | Read-buffer write data |
| ctrlDone | input | 1 | Completion pulse from the controller |
| ctrlErr | input | 1 | Error flag posted with completion |
| ctrlErrCode | input | 8 | Error code posted with completion |

## Verification
The embedded assertions check, cycle by cycle, the busy handshake: busy holds until a completion, ctrlIrq and hostIrq last one cycle, and a rise of busy comes with a controller interrupt. They also check that the command word stays frozen while busy and that the read buffer stays stable without a controller strobe. The byte-level contents, such as byte-enable merging in the write buffer, misaligned read-buffer windows and zero fill past the end, are shown only by the bench. The same holds for the exact status word after each mix of overrun, error code and completion-interrupt request, and for sweeps over every command id and byte-enable pattern.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam int WIN_AW = 8;

  localparam logic [WIN_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_STAT = 8'h04;
  localparam logic [WIN_AW-1:0] OFS_SRC  = 8'h08;
  localparam logic [WIN_AW-1:0] OFS_DST  = 8'h0C;
  localparam logic [WIN_AW-1:0] OFS_WBUF = 8'h80;
  localparam logic [WIN_AW-1:0] OFS_RBUF = 8'h90;

  localparam int CMD_IOC_BIT   = 8;
  localparam int CMD_ID_LSB    = 12;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_OVR_BIT  = 2;
  localparam int STAT_ID_LSB   = 4;
  localparam int STAT_INIT_LSB = 8;
  localparam int STAT_CODE_LSB = 16;

  typedef struct packed {
    logic cmdLoad;
    logic srcLoad;
    logic dstLoad;
    logic wbufLoad;
    logic doneLoad;
  } mboxStrobe_t;

  function automatic logic [31:0] beMerge(input logic [31:0] oldWord,
                                          input logic [31:0] newWord,
                                          input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++)
      res[b*8 +: 8] = be[b] ? newWord[b*8 +: 8] : oldWord[b*8 +: 8];
    return res;
  endfunction

endpackage

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter int WBUF_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [WIN_AW-1:0] hostAddr,
  input  logic              iocReq,
  input  logic              ctrlDone,
  output mboxStrobe_t       strobe,
  output logic              busy,
  output logic              overrun,
  output logic              ctrlIrq,
  output logic              hostIrq
);

  logic hostWr;
  logic cmdHit;
  logic wbufHit;
  logic iocLatched;

  assign hostWr  = hostSel && hostWrite;
  assign cmdHit  = hostWr && (hostAddr == OFS_CMD);
  assign wbufHit = (int'(hostAddr) >= int'(OFS_WBUF)) &&
                   (int'(hostAddr) <  int'(OFS_WBUF) + WBUF_BYTES) &&
                   (hostAddr[1:0] == 2'b00);

  always_comb begin
    strobe          = '0;
    strobe.cmdLoad  = cmdHit && !busy;
    strobe.srcLoad  = hostWr && (hostAddr == OFS_SRC);
    strobe.dstLoad  = hostWr && (hostAddr == OFS_DST);
    strobe.wbufLoad = hostWr && wbufHit;
    strobe.doneLoad = ctrlDone && busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      overrun    <= 1'b0;
      iocLatched <= 1'b0;
      ctrlIrq    <= 1'b0;
      hostIrq    <= 1'b0;
    end else begin
      ctrlIrq <= strobe.cmdLoad;
      hostIrq <= strobe.doneLoad && iocLatched;
      if (strobe.cmdLoad) begin
        busy       <= 1'b1;
        iocLatched <= iocReq;
        overrun    <= 1'b0;
      end else begin
        if (strobe.doneLoad) busy <= 1'b0;
        if (cmdHit)          overrun <= 1'b1;
      end
    end
  end

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctrlDone) |=> busy);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ctrlIrq);

  assert_ctrl_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIrq |=> !ctrlIrq);

  assert_host_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (!busy && !$past(hostIrq)));

  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWrite && hostAddr == OFS_CMD && busy) |=> (overrun && !ctrlIrq));

endmodule

// File: rtl/ipc_mbox_dp.sv
module ipc_mbox_dp
  import ipc_mbox_pkg::*;
#(
  parameter int          WBUF_BYTES = 16,
  parameter int          RBUF_BYTES = 16,
  parameter logic [7:0]  INIT_ID    = 8'hA5,
  localparam int         WB_WORDS   = WBUF_BYTES / 4,
  localparam int         RB_WORDS   = RBUF_BYTES / 4,
  localparam int         WB_IW      = $clog2(WB_WORDS),
  localparam int         RB_IW      = $clog2(RB_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobe,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [WIN_AW-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic [3:0]        hostBe,
  input  logic              busy,
  input  logic              overrun,
  input  logic              ctrlErr,
  input  logic [7:0]        ctrlErrCode,
  input  logic [WB_IW-1:0]  ctrlWbufIdx,
  input  logic              ctrlRbufWe,
  input  logic [RB_IW-1:0]  ctrlRbufIdx,
  input  logic [3:0]        ctrlRbufBe,
  input  logic [31:0]       ctrlRbufData,
  output logic [31:0]       hostRdata,
  output logic [31:0]       ctrlCmd,
  output logic [31:0]       ctrlSrcPtr,
  output logic [31:0]       ctrlDstPtr,
  output logic [31:0]       ctrlWbufData
);

  logic [WBUF_BYTES*8-1:0] wbuf;
  logic [RBUF_BYTES*8-1:0] rbuf;
  logic                    errFlag;
  logic [7:0]              errCode;
  logic [3:0]              cmdId;
  logic [31:0]             statWord;
  logic [31:0]             rbufWord;
  int                      wbufWordSel;
  int                      rbufBase;

  assign wbufWordSel = (int'(hostAddr) - int'(OFS_WBUF)) >>> 2;
  assign rbufBase    = int'(hostAddr) - int'(OFS_RBUF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlCmd    <= '0;
      ctrlSrcPtr <= '0;
      ctrlDstPtr <= '0;
      cmdId      <= '0;
      errFlag    <= 1'b0;
      errCode    <= '0;
    end else begin
      if (strobe.cmdLoad) begin
        ctrlCmd <= hostWdata;
        cmdId   <= hostWdata[CMD_ID_LSB +: 4];
        errFlag <= 1'b0;
        errCode <= '0;
      end else if (strobe.doneLoad) begin
        errFlag <= ctrlErr;
        errCode <= ctrlErrCode;
      end
      if (strobe.srcLoad) ctrlSrcPtr <= beMerge(ctrlSrcPtr, hostWdata, hostBe);
      if (strobe.dstLoad) ctrlDstPtr <= beMerge(ctrlDstPtr, hostWdata, hostBe);
    end
  end

  generate
    for (genvar w = 0; w < WB_WORDS; w++) begin : gWbuf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          wbuf[w*32 +: 32] <= '0;
        else if (strobe.wbufLoad && wbufWordSel == w)
          wbuf[w*32 +: 32] <= beMerge(wbuf[w*32 +: 32], hostWdata, hostBe);
      end
    end
    for (genvar w = 0; w < RB_WORDS; w++) begin : gRbuf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          rbuf[w*32 +: 32] <= '0;
        else if (ctrlRbufWe && int'(ctrlRbufIdx) == w)
          rbuf[w*32 +: 32] <= beMerge(rbuf[w*32 +: 32], ctrlRbufData, ctrlRbufBe);
      end
    end
  endgenerate

  assign ctrlWbufData = wbuf[int'(ctrlWbufIdx)*32 +: 32];

  always_comb begin
    statWord = '0;
    statWord[STAT_BUSY_BIT]        = busy;
    statWord[STAT_ERR_BIT]         = errFlag;
    statWord[STAT_OVR_BIT]         = overrun;
    statWord[STAT_ID_LSB +: 4]     = cmdId;
    statWord[STAT_INIT_LSB +: 8]   = INIT_ID;
    statWord[STAT_CODE_LSB +: 8]   = errCode;
  end

  always_comb begin
    rbufWord = '0;
    for (int k = 0; k < 4; k++) begin
      if (rbufBase + k < RBUF_BYTES)
        rbufWord[k*8 +: 8] = rbuf[(rbufBase + k)*8 +: 8];
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostSel && !hostWrite) begin
      if (hostAddr == OFS_STAT)
        hostRdata = statWord;
      else if (rbufBase >= 0 && rbufBase < RBUF_BYTES)
        hostRdata = rbufWord;
    end
  end

  assert_rbuf_ctrl_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRbufWe |=> $stable(rbuf));

  assert_cmd_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(ctrlCmd) && $stable(cmdId)));

  assert_done_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneLoad |=> (errCode == $past(ctrlErrCode) && errFlag == $past(ctrlErr)));

  assert_status_reserved_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[31:24] == 8'h00 && statWord[3] == 1'b0));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int         WBUF_BYTES = 16,
  parameter int         RBUF_BYTES = 16,
  parameter logic [7:0] INIT_ID    = 8'hA5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                hostSel,
  input  logic                                hostWrite,
  input  logic [7:0]                          hostAddr,
  input  logic [31:0]                         hostWdata,
  input  logic [3:0]                          hostBe,
  output logic [31:0]                         hostRdata,
  output logic                                hostIrq,
  output logic                                ctrlIrq,
  output logic                                ctrlBusy,
  output logic [31:0]                         ctrlCmd,
  output logic [31:0]                         ctrlSrcPtr,
  output logic [31:0]                         ctrlDstPtr,
  input  logic [$clog2(WBUF_BYTES/4)-1:0]     ctrlWbufIdx,
  output logic [31:0]                         ctrlWbufData,
  input  logic                                ctrlRbufWe,
  input  logic [$clog2(RBUF_BYTES/4)-1:0]     ctrlRbufIdx,
  input  logic [3:0]                          ctrlRbufBe,
  input  logic [31:0]                         ctrlRbufData,
  input  logic                                ctrlDone,
  input  logic                                ctrlErr,
  input  logic [7:0]                          ctrlErrCode
);

  mboxStrobe_t strobe;
  logic        busy;
  logic        overrun;

  ipc_mbox_ctrl #(.WBUF_BYTES(WBUF_BYTES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .iocReq   (hostWdata[CMD_IOC_BIT]),
    .ctrlDone (ctrlDone),
    .strobe   (strobe),
    .busy     (busy),
    .overrun  (overrun),
    .ctrlIrq  (ctrlIrq),
    .hostIrq  (hostIrq)
  );

  ipc_mbox_dp #(
    .WBUF_BYTES(WBUF_BYTES),
    .RBUF_BYTES(RBUF_BYTES),
    .INIT_ID   (INIT_ID)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostSel     (hostSel),
    .hostWrite   (hostWrite),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .hostBe      (hostBe),
    .busy        (busy),
    .overrun     (overrun),
    .ctrlErr     (ctrlErr),
    .ctrlErrCode (ctrlErrCode),
    .ctrlWbufIdx (ctrlWbufIdx),
    .ctrlRbufWe  (ctrlRbufWe),
    .ctrlRbufIdx (ctrlRbufIdx),
    .ctrlRbufBe  (ctrlRbufBe),
    .ctrlRbufData(ctrlRbufData),
    .hostRdata   (hostRdata),
    .ctrlCmd     (ctrlCmd),
    .ctrlSrcPtr  (ctrlSrcPtr),
    .ctrlDstPtr  (ctrlDstPtr),
    .ctrlWbufData(ctrlWbufData)
  );

  assign ctrlBusy = busy;

endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;

  localparam logic [7:0] TB_INIT = 8'hA5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWrite = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [3:0]  hostBe = '0;
  logic [31:0] hostRdata;
  logic        hostIrq;
  logic        ctrlIrq;
  logic        ctrlBusy;
  logic [31:0] ctrlCmd;
  logic [31:0] ctrlSrcPtr;
  logic [31:0] ctrlDstPtr;
  logic [1:0]  ctrlWbufIdx = '0;
  logic [31:0] ctrlWbufData;
  logic        ctrlRbufWe = 1'b0;
  logic [1:0]  ctrlRbufIdx = '0;
  logic [3:0]  ctrlRbufBe = '0;
  logic [31:0] ctrlRbufData = '0;
  logic        ctrlDone = 1'b0;
  logic        ctrlErr = 1'b0;
  logic [7:0]  ctrlErrCode = '0;

  int testCount = 0;
  int failCount = 0;

  logic [31:0] expWb [4];
  logic [7:0]  expRb [16];

  always #5 clk = ~clk;

  ipc_mailbox #(.WBUF_BYTES(16), .RBUF_BYTES(16), .INIT_ID(TB_INIT)) uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostRdata(hostRdata), .hostIrq(hostIrq), .ctrlIrq(ctrlIrq),
    .ctrlBusy(ctrlBusy), .ctrlCmd(ctrlCmd), .ctrlSrcPtr(ctrlSrcPtr),
    .ctrlDstPtr(ctrlDstPtr), .ctrlWbufIdx(ctrlWbufIdx),
    .ctrlWbufData(ctrlWbufData), .ctrlRbufWe(ctrlRbufWe),
    .ctrlRbufIdx(ctrlRbufIdx), .ctrlRbufBe(ctrlRbufBe),
    .ctrlRbufData(ctrlRbufData), .ctrlDone(ctrlDone), .ctrlErr(ctrlErr),
    .ctrlErrCode(ctrlErrCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statExp(input logic bsy, input logic err,
                                          input logic ovr, input logic [3:0] id,
                                          input logic [7:0] code);
    return {8'h00, code, TB_INIT, id, 1'b0, ovr, err, bsy};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b1; hostAddr = a; hostWdata = d; hostBe = be;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0; hostWdata = '0; hostBe = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic ctrlFinish(input logic err, input logic [7:0] code);
    @(negedge clk);
    ctrlDone = 1'b1; ctrlErr = err; ctrlErrCode = code;
    @(negedge clk);
    ctrlDone = 1'b0; ctrlErr = 1'b0; ctrlErrCode = '0;
  endtask

  task automatic ctrlRbufWrite(input logic [1:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    ctrlRbufWe = 1'b1; ctrlRbufIdx = idx; ctrlRbufData = d; ctrlRbufBe = be;
    @(negedge clk);
    ctrlRbufWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cmdWord;
    logic [31:0] keptCmd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(8'h04, rd);
    check("R1 status after reset", rd, statExp(0, 0, 0, 4'h0, 8'h00));
    check("R1 hostIrq after reset", {31'b0, hostIrq}, 32'd0);
    check("R1 ctrlIrq after reset", {31'b0, ctrlIrq}, 32'd0);

    // R8 pointers with byte enables
    busWrite(8'h08, 32'h1122_3344, 4'hF);
    check("R8 source pointer", ctrlSrcPtr, 32'h1122_3344);
    busWrite(8'h0C, 32'hAABB_CCDD, 4'b0101);
    check("R8 destination partial", ctrlDstPtr, 32'h00BB_00DD);
    busWrite(8'h0C, 32'h9988_7766, 4'b1000);
    check("R8 destination merge", ctrlDstPtr, 32'h99BB_00DD);

    // R7 write-only and unmapped reads
    busRead(8'h08, rd); check("R7 source read zero", rd, 32'd0);
    busRead(8'h0C, rd); check("R7 dest read zero", rd, 32'd0);
    busRead(8'h40, rd); check("R7 unmapped read zero", rd, 32'd0);
    busRead(8'hFC, rd); check("R7 top unmapped read zero", rd, 32'd0);

    // R9 write buffer: every word, every byte-enable pattern
    for (int w = 0; w < 4; w++) expWb[w] = '0;
    for (int w = 0; w < 4; w++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (w * 16 + be + 1);
        busWrite(8'h80 + 8'(w * 4), d, 4'(be));
        expWb[w] = merge(expWb[w], d, 4'(be));
        ctrlWbufIdx = 2'(w);
        #1 check($sformatf("R9 wbuf word %0d be %0d", w, be), ctrlWbufData, expWb[w]);
      end
    end
    for (int w = 0; w < 4; w++) begin
      ctrlWbufIdx = 2'(w);
      #1 check($sformatf("R9 wbuf retained word %0d", w), ctrlWbufData, expWb[w]);
    end
    busRead(8'h84, rd); check("R7 wbuf read zero", rd, 32'd0);

    // R10 fill read buffer from controller
    for (int i = 0; i < 16; i++) expRb[i] = 8'(8'h30 + i * 7);
    for (int w = 0; w < 4; w++)
      ctrlRbufWrite(2'(w), {expRb[w*4+3], expRb[w*4+2], expRb[w*4+1], expRb[w*4]}, 4'hF);
    busWrite(8'h90, 32'hDEAD_BEEF, 4'hF);
    busWrite(8'h9C, 32'hDEAD_BEEF, 4'hF);
    busWrite(8'h04, 32'hFFFF_FFFF, 4'hF);
    busRead(8'h90, rd);
    check("R10 host write to rbuf ignored", rd, {expRb[3], expRb[2], expRb[1], expRb[0]});
    busRead(8'h9C, rd);
    check("R10 host write to rbuf tail ignored", rd, {expRb[15], expRb[14], expRb[13], expRb[12]});
    busRead(8'h04, rd);
    check("R10 host write to status ignored", rd, statExp(0, 0, 0, 4'h0, 8'h00));
    ctrlRbufWrite(2'd1, 32'hFFFF_FFFF, 4'b0010);
    expRb[5] = 8'hFF;

    // R11 read window at every byte offset
    for (int n = 0; n < 16; n++) begin
      logic [31:0] e;
      e = '0;
      for (int k = 0; k < 4; k++) if (n + k < 16) e[k*8 +: 8] = expRb[n+k];
      busRead(8'h90 + 8'(n), rd);
      check($sformatf("R11 rbuf offset %0d", n), rd, e);
    end

    // R2 accepted command
    cmdWord = (32'd8 << 16) | (32'hA << 12) | (32'd1 << 8) | 32'h3C;
    busWrite(8'h00, cmdWord, 4'hF);
    check("R2 ctrlIrq pulse", {31'b0, ctrlIrq}, 32'd1);
    check("R2 command word", ctrlCmd, cmdWord);
    busRead(8'h00, rd);
    check("R7 command read zero", rd, 32'd0);
    check("R2 ctrlIrq one cycle", {31'b0, ctrlIrq}, 32'd0);
    busRead(8'h04, rd);
    check("R2 status busy and id", rd, statExp(1, 0, 0, 4'hA, 8'h00));

    // R3 busy holds
    repeat (10) @(negedge clk);
    busRead(8'h04, rd);
    check("R3 busy held while waiting", rd, statExp(1, 0, 0, 4'hA, 8'h00));

    // R6 dropped command while busy
    keptCmd = cmdWord;
    busWrite(8'h00, 32'h0000_7155, 4'hF);
    check("R6 no ctrlIrq on drop", {31'b0, ctrlIrq}, 32'd0);
    check("R6 command kept", ctrlCmd, keptCmd);
    busRead(8'h04, rd);
    check("R6 overrun recorded", rd, statExp(1, 0, 1, 4'hA, 8'h00));

    // R4 R5 completion with error and ioc
    ctrlFinish(1'b1, 8'h5B);
    check("R5 hostIrq on completion", {31'b0, hostIrq}, 32'd1);
    busRead(8'h04, rd);
    check("R4 error posted with busy clear", rd, statExp(0, 1, 1, 4'hA, 8'h5B));
    check("R5 hostIrq one cycle", {31'b0, hostIrq}, 32'd0);

    // R3 completion while idle has no effect
    ctrlFinish(1'b0, 8'h00);
    check("R3 idle done no hostIrq", {31'b0, hostIrq}, 32'd0);
    busRead(8'h04, rd);
    check("R3 idle done status unchanged", rd, statExp(0, 1, 1, 4'hA, 8'h5B));

    // R4 R6 new command clears error and overrun
    cmdWord = (32'd4 << 16) | (32'h3 << 12) | 32'h11;
    busWrite(8'h00, cmdWord, 4'hF);
    check("R2 second command", ctrlCmd, cmdWord);
    busRead(8'h04, rd);
    check("R4 R6 cleared on accept", rd, statExp(1, 0, 0, 4'h3, 8'h00));
    ctrlFinish(1'b0, 8'h00);
    check("R5 no hostIrq without request", {31'b0, hostIrq}, 32'd0);
    busRead(8'h04, rd);
    check("R4 clean completion", rd, statExp(0, 0, 0, 4'h3, 8'h00));

    // R2 R4 R5 sweep over every command id
    for (int id = 0; id < 16; id++) begin
      logic ioc;
      logic err;
      ioc = id[0];
      err = id[1];
      cmdWord = (32'(id) << 12) | (32'(ioc) << 8) | 32'(8'hC0 + id);
      busWrite(8'h00, cmdWord, 4'hF);
      check($sformatf("R2 sweep ctrlIrq id %0d", id), {31'b0, ctrlIrq}, 32'd1);
      busRead(8'h04, rd);
      check($sformatf("R2 sweep status id %0d", id), rd, statExp(1, 0, 0, 4'(id), 8'h00));
      ctrlFinish(err, 8'(id * 17));
      check($sformatf("R5 sweep hostIrq id %0d", id), {31'b0, hostIrq}, {31'b0, ioc});
      busRead(8'h04, rd);
      check($sformatf("R4 sweep completion id %0d", id), rd,
            statExp(0, err, 0, 4'(id), 8'(id * 17)));
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule